// File: doc/BRIEF.md
# Delayed-Branch Pipeline Sequencer with Load Lock

This block is a small in-order sequencer for a machine in which every arithmetic instruction works register to register. It fetches one 16-bit instruction per cycle from an instruction port and executes it against an eight-entry register file. Arithmetic, jumps and branches finish in two stages: fetch, then execute. Loads and stores add a third stage that holds the request on the data port until the memory raises its ready signal.

Control transfers are delayed. The instruction right after a taken jump or branch is always executed before the target is fetched. Loads do not stop the pipeline. A load marks its destination register as locked. Later instructions that neither read nor write that register keep issuing while the memory works. The first one that touches the register waits until the load data has been written.

Top module: `dsb_core`

## Requirements
- R1: While reset is held (synchronous, active low), the next fetch address is 0 and no data request is made. All eight registers read as 0 once reset is released.
- R2: Instruction fields are opcode [15:12], rd [11:9], rs1 [8:6] and rs2 [5:3]. Opcodes 1 to 5 write rd with rs1+rs2, rs1-rs2, rs1&rs2, rs1|rs2 and rs1^rs2, in that order, using 16-bit wraparound.
- R3: Opcode 6 writes rd with rs1 plus the sign-extended 6-bit immediate in [5:0].
- R4: Opcode 7 loads rd and opcode 8 stores rd. Both use address rs1 plus the sign-extended [5:0], truncated to the data address width. A request keeps its address, direction and write data until the cycle in which ready is high.
- R5: Opcode 9 always jumps and opcode 10 branches when rd equals 0. The target is the control instruction's own address plus the sign-extended 9-bit field [8:0]. The following instruction (the delay slot) always executes, and fetch moves to the target after it.
- R6: A jump or branch that sits in the delay slot of any jump or branch executes without redirecting fetch.
- R7: Instructions that neither read nor write the locked register keep issuing while a load is outstanding.
- R8: An instruction that reads the locked register stalls. It executes one cycle after the cycle in which ready returns the load data, and it sees the loaded value.
- R9: Only one memory operation is outstanding at a time. A second load or store stalls until the first completes, and no new request is made in the cycle after a completion.
- R10: A non-load instruction that writes the locked register stalls until the load completes, so that its own value is the one that remains.
- R11: The load data is written, and the lock cleared, at the clock edge where ready is high.
- R12: Opcodes 0 and 11 to 15 change no register and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | PCW | Address of the instruction being fetched |
| imem_rdata | input | 16 | Instruction word for imem_addr, valid in the same cycle |
| dmem_req | output | 1 | Data request pending |
| dmem_we | output | 1 | 1 for store, 0 for load |
| dmem_addr | output | DAW | Data address |
| dmem_wdata | output | DW | Store data |
| dmem_rdata | input | DW | Load data, valid when dmem_ready is high |
| dmem_ready | input | 1 | Completes the pending request this cycle |

## Verification
The bench builds the core with PCW = 6, DAW = 6 and DW = 16. A 64-word program image therefore covers the whole fetch space. Effective addresses wrap within a 64-word data memory, so wraparound of the address sum and collisions between random loads and stores both occur often. Random programs are run with random memory latency and compared, store by store, against an instruction-level model that has delayed-branch semantics. Fixed long latencies expose the exact fetch address during lock stalls, so the cycles at which the pipeline stops and resumes can be checked.

// File: rtl/dsb_pkg.sv
// Shared opcode constants, ALU selector and decoded control bundle for the
// delayed-branch sequencer. Assumes the fixed 16-bit instruction layout.
package dsb_pkg;

    localparam int IW    = 16;
    localparam int RIDXW = 3;

    localparam logic [3:0] OP_ADD  = 4'd1;
    localparam logic [3:0] OP_SUB  = 4'd2;
    localparam logic [3:0] OP_AND  = 4'd3;
    localparam logic [3:0] OP_OR   = 4'd4;
    localparam logic [3:0] OP_XOR  = 4'd5;
    localparam logic [3:0] OP_ADDI = 4'd6;
    localparam logic [3:0] OP_LD   = 4'd7;
    localparam logic [3:0] OP_ST   = 4'd8;
    localparam logic [3:0] OP_JMP  = 4'd9;
    localparam logic [3:0] OP_BEQZ = 4'd10;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4
    } alu_e;

    typedef struct packed {
        logic rd_rs1;
        logic rd_rs2;
        logic rd_rd;
        logic wr_rd;
        logic use_imm;
        logic is_ld;
        logic is_st;
        logic is_ctrl;
        logic is_cond;
        alu_e alu;
    } ctl_t;

    // Turn an opcode into the control bundle used by the execute stage.
    function automatic ctl_t decode_op(input logic [3:0] op);
        ctl_t c;
        c     = '0;
        c.alu = ALU_ADD;
        case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
                c.rd_rs1 = 1'b1;
                c.rd_rs2 = 1'b1;
                c.wr_rd  = 1'b1;
                case (op)
                    OP_SUB:  c.alu = ALU_SUB;
                    OP_AND:  c.alu = ALU_AND;
                    OP_OR:   c.alu = ALU_OR;
                    OP_XOR:  c.alu = ALU_XOR;
                    default: c.alu = ALU_ADD;
                endcase
            end
            OP_ADDI: begin
                c.rd_rs1  = 1'b1;
                c.wr_rd   = 1'b1;
                c.use_imm = 1'b1;
            end
            OP_LD: begin
                c.rd_rs1 = 1'b1;
                c.wr_rd  = 1'b1;
                c.is_ld  = 1'b1;
            end
            OP_ST: begin
                c.rd_rs1 = 1'b1;
                c.rd_rd  = 1'b1;
                c.is_st  = 1'b1;
            end
            OP_JMP: begin
                c.is_ctrl = 1'b1;
            end
            OP_BEQZ: begin
                c.is_ctrl = 1'b1;
                c.is_cond = 1'b1;
                c.rd_rd   = 1'b1;
            end
            default: c = c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dsb_regfile.sv
// Register file with three combinational read ports and two write ports.
// Port B (load return) takes priority over port A (execute result).
// The hazard logic keeps the two ports from naming the same entry.
module dsb_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_idx,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_idx,
    input  logic [DW-1:0] wb_data,
    input  logic [AW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_idx,
    output logic [DW-1:0] rb_data,
    input  logic [AW-1:0] rc_idx,
    output logic [DW-1:0] rc_data
);

    logic [NREG-1:0][DW-1:0] file_q;

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic [DW-1:0] q;
        // Hold one register; clear on reset, load return wins over execute.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wb_en && wb_idx == AW'(g))
                q <= wb_data;
            else if (wa_en && wa_idx == AW'(g))
                q <= wa_data;
        end
        assign file_q[g] = q;
    end

    assign ra_data = file_q[ra_idx];
    assign rb_data = file_q[rb_idx];
    assign rc_data = file_q[rc_idx];

endmodule

// File: rtl/dsb_fetch.sv
// Program counter and fetch/execute pipeline register. On a redirect the
// instruction already being fetched (the delay slot) is kept; only the next
// fetch address changes. Assumes the instruction port answers in the same cycle.
module dsb_fetch #(
    parameter int PCW = 10,
    parameter int IW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           redirect,
    input  logic [PCW-1:0] target,
    input  logic           ctrl_now,
    output logic [PCW-1:0] imem_addr,
    input  logic [IW-1:0]  imem_rdata,
    output logic           ex_valid,
    output logic [IW-1:0]  ex_instr,
    output logic [PCW-1:0] ex_pc,
    output logic           ex_slot
);

    logic [PCW-1:0] pc_q;

    // Advance the fetch address and capture the fetched word unless held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            ex_valid <= 1'b0;
            ex_instr <= '0;
            ex_pc    <= '0;
            ex_slot  <= 1'b0;
        end else if (!hold) begin
            pc_q     <= redirect ? target : pc_q + PCW'(1);
            ex_valid <= 1'b1;
            ex_instr <= imem_rdata;
            ex_pc    <= pc_q;
            ex_slot  <= ctrl_now;
        end
    end

    assign imem_addr = pc_q;

endmodule

// File: rtl/dsb_lsu.sv
// Memory stage: holds a single load or store until ready. While a load is
// pending it reports its destination as locked; the data is handed to the
// register file in the ready cycle. Assumes issue is only raised when idle.
module dsb_lsu #(
    parameter int DW  = 16,
    parameter int DAW = 12,
    parameter int AW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue,
    input  logic           issue_we,
    input  logic [DAW-1:0] issue_addr,
    input  logic [DW-1:0]  issue_data,
    input  logic [AW-1:0]  issue_rd,
    output logic           busy,
    output logic           lock_valid,
    output logic [AW-1:0]  lock_rd,
    output logic           ld_wen,
    output logic [AW-1:0]  ld_idx,
    output logic [DW-1:0]  ld_data,
    output logic           dmem_req,
    output logic           dmem_we,
    output logic [DAW-1:0] dmem_addr,
    output logic [DW-1:0]  dmem_wdata,
    input  logic [DW-1:0]  dmem_rdata,
    input  logic           dmem_ready
);

    logic           m_valid;
    logic           m_we;
    logic [DAW-1:0] m_addr;
    logic [DW-1:0]  m_data;
    logic [AW-1:0]  m_rd;

    // Capture a new request, or retire the pending one when ready arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_we    <= 1'b0;
            m_addr  <= '0;
            m_data  <= '0;
            m_rd    <= '0;
        end else if (m_valid && dmem_ready) begin
            m_valid <= 1'b0;
        end else if (issue) begin
            m_valid <= 1'b1;
            m_we    <= issue_we;
            m_addr  <= issue_addr;
            m_data  <= issue_data;
            m_rd    <= issue_rd;
        end
    end

    assign busy       = m_valid;
    assign lock_valid = m_valid && !m_we;
    assign lock_rd    = m_rd;
    assign ld_wen     = m_valid && !m_we && dmem_ready;
    assign ld_idx     = m_rd;
    assign ld_data    = dmem_rdata;
    assign dmem_req   = m_valid;
    assign dmem_we    = m_we;
    assign dmem_addr  = m_addr;
    assign dmem_wdata = m_data;

endmodule

// File: rtl/dsb_core.sv
// Top of the delayed-branch sequencer: decode, operand read, ALU, branch
// resolution and the lock/structural stall logic around fetch, register file
// and memory stage. Assumes DW > 6 and DAW <= DW.
module dsb_core #(
    parameter int PCW = 10,
    parameter int DAW = 12,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [PCW-1:0] imem_addr,
    input  logic [15:0]    imem_rdata,
    output logic           dmem_req,
    output logic           dmem_we,
    output logic [DAW-1:0] dmem_addr,
    output logic [DW-1:0]  dmem_wdata,
    input  logic [DW-1:0]  dmem_rdata,
    input  logic           dmem_ready
);
    import dsb_pkg::*;

    localparam int NREG = 1 << RIDXW;

    logic             ex_valid, ex_slot;
    logic [IW-1:0]    ex_instr;
    logic [PCW-1:0]   ex_pc;
    ctl_t             ctl;
    logic [RIDXW-1:0] f_rd, f_rs1, f_rs2;
    logic [DW-1:0]    rs1v, rs2v, rdv, imm6x, opb, alu_y;
    logic [PCW-1:0]   imm9p, br_target;
    logic [DAW-1:0]   eff_addr;
    logic             busy, lock_valid, ld_wen;
    logic [RIDXW-1:0] lock_rd, ld_idx;
    logic [DW-1:0]    ld_data;
    logic             hit_lock, mem_block, stall, go, taken, redirect;

    assign ctl   = decode_op(ex_instr[15:12]);
    assign f_rd  = ex_instr[11:9];
    assign f_rs1 = ex_instr[8:6];
    assign f_rs2 = ex_instr[5:3];
    assign imm6x = {{(DW-6){ex_instr[5]}}, ex_instr[5:0]};

    // Fit the 9-bit branch offset to the program counter width.
    if (PCW > 9) begin : g_off_ext
        assign imm9p = {{(PCW-9){ex_instr[8]}}, ex_instr[8:0]};
    end else begin : g_off_trunc
        assign imm9p = ex_instr[PCW-1:0];
    end

    dsb_fetch #(.PCW(PCW), .IW(IW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (stall),
        .redirect   (redirect),
        .target     (br_target),
        .ctrl_now   (go && ctl.is_ctrl),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .ex_valid   (ex_valid),
        .ex_instr   (ex_instr),
        .ex_pc      (ex_pc),
        .ex_slot    (ex_slot)
    );

    dsb_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (go && ctl.wr_rd && !ctl.is_ld),
        .wa_idx  (f_rd),
        .wa_data (alu_y),
        .wb_en   (ld_wen),
        .wb_idx  (ld_idx),
        .wb_data (ld_data),
        .ra_idx  (f_rs1),
        .ra_data (rs1v),
        .rb_idx  (f_rs2),
        .rb_data (rs2v),
        .rc_idx  (f_rd),
        .rc_data (rdv)
    );

    // Register or immediate second operand, then the selected operation.
    always_comb begin
        opb = ctl.use_imm ? imm6x : rs2v;
        unique case (ctl.alu)
            ALU_SUB: alu_y = rs1v - opb;
            ALU_AND: alu_y = rs1v & opb;
            ALU_OR:  alu_y = rs1v | opb;
            ALU_XOR: alu_y = rs1v ^ opb;
            default: alu_y = rs1v + opb;
        endcase
    end

    // Stall on any touch of the locked register or on a busy memory stage.
    always_comb begin
        hit_lock  = lock_valid && ((ctl.rd_rs1 && f_rs1 == lock_rd) ||
                                   (ctl.rd_rs2 && f_rs2 == lock_rd) ||
                                   ((ctl.rd_rd || ctl.wr_rd) && f_rd == lock_rd));
        mem_block = (ctl.is_ld || ctl.is_st) && busy;
        stall     = ex_valid && (hit_lock || mem_block);
        go        = ex_valid && !stall;
    end

    // Resolve control transfers; a transfer in a delay slot never redirects.
    always_comb begin
        taken     = ctl.is_ctrl && (!ctl.is_cond || rdv == '0);
        redirect  = go && taken && !ex_slot;
        br_target = ex_pc + imm9p;
        eff_addr  = rs1v[DAW-1:0] + imm6x[DAW-1:0];
    end

    dsb_lsu #(.DW(DW), .DAW(DAW), .AW(RIDXW)) u_lsu (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (go && (ctl.is_ld || ctl.is_st)),
        .issue_we   (ctl.is_st),
        .issue_addr (eff_addr),
        .issue_data (rdv),
        .issue_rd   (f_rd),
        .busy       (busy),
        .lock_valid (lock_valid),
        .lock_rd    (lock_rd),
        .ld_wen     (ld_wen),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .dmem_req   (dmem_req),
        .dmem_we    (dmem_we),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .dmem_ready (dmem_ready)
    );

endmodule

// File: rtl/dsb_core_chk.sv
// Property checker for dsb_core, attached by bind. Observes the ports plus
// the stall, lock and redirect signals that join fetch, execute and memory.
module dsb_core_chk #(
    parameter int PCW = 10,
    parameter int DAW = 12,
    parameter int DW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [PCW-1:0] imem_addr,
    input logic           dmem_req,
    input logic           dmem_we,
    input logic [DAW-1:0] dmem_addr,
    input logic [DW-1:0]  dmem_wdata,
    input logic           dmem_ready,
    input logic           stall,
    input logic           lock_valid,
    input logic           redirect,
    input logic [PCW-1:0] br_target
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!dmem_req && imem_addr == '0));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_req && !dmem_ready) |=> (dmem_req && $stable(dmem_we) &&
                                       $stable(dmem_addr) && $stable(dmem_wdata)));

    // R9
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_req && dmem_ready) |=> !dmem_req);

    // R8
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(imem_addr));

    // R11
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_valid && dmem_ready) |=> !lock_valid);

    // R5
    redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> imem_addr == $past(br_target));

endmodule

bind dsb_core dsb_core_chk #(.PCW(PCW), .DAW(DAW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .dmem_req   (dmem_req),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_ready (dmem_ready),
    .stall      (stall),
    .lock_valid (lock_valid),
    .redirect   (redirect),
    .br_target  (br_target)
);

// File: tb/test_dsb_core.sv
`timescale 1ns/1ps
module test_dsb_core;

    localparam int PCW = 6;
    localparam int DAW = 6;
    localparam int DW  = 16;
    localparam int NP  = 1 << PCW;
    localparam int ND  = 1 << DAW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [PCW-1:0] imem_addr;
    logic [15:0]    imem_rdata;
    logic           dmem_req, dmem_we;
    logic [DAW-1:0] dmem_addr;
    logic [DW-1:0]  dmem_wdata;
    logic [DW-1:0]  dmem_rdata;
    logic           dmem_ready;

    logic [15:0] prog [NP];
    logic [15:0] dmem [ND];
    logic [15:0] mmem [ND];
    logic [15:0] mreg [8];
    logic [DAW-1:0] act_addr [128];
    logic [15:0]    act_data [128];
    logic [DAW-1:0] exp_addr [128];
    logic [15:0]    exp_data [128];
    int act_n, exp_n;
    int lat_fix, cur_lat, wcnt;
    int n_chk = 0, n_fail = 0, cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign imem_rdata = prog[imem_addr];

    dsb_core #(.PCW(PCW), .DAW(DAW), .DW(DW)) i_dsb_core (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata), .dmem_ready(dmem_ready)
    );

    function automatic logic [15:0] enc_r(int op, int rd, int rs1, int rs2);
        return {4'(op), 3'(rd), 3'(rs1), 3'(rs2), 3'd0};
    endfunction
    function automatic logic [15:0] enc_i(int op, int rd, int rs1, int imm);
        return {4'(op), 3'(rd), 3'(rs1), 6'(imm)};
    endfunction
    function automatic logic [15:0] enc_b(int op, int rd, int off);
        return {4'(op), 3'(rd), 9'(off)};
    endfunction
    function automatic logic [15:0] memval(int a);
        return 16'(a * 16'h0123 + 16'h1357);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic sample;
        @(negedge clk);
        #1;
    endtask

    // Instruction-level model with one delay slot (R2 R3 R4 R5 R6 R12).
    task automatic model_run(input int steps);
        int pc = 0, pend = 0;
        bit pend_v = 0, slot = 0;
        exp_n = 0;
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        for (int a = 0; a < ND; a++) mmem[a] = memval(a);
        for (int s = 0; s < steps; s++) begin
            logic [15:0] ins = prog[pc];
            int op = ins[15:12], rd = ins[11:9], r1 = ins[8:6], r2 = ins[5:3];
            logic [15:0] i6 = {{10{ins[5]}}, ins[5:0]};
            int off = int'($signed(ins[8:0]));
            int nxt = pend_v ? pend : (pc + 1) % NP;
            bit ctrl = (op == 9 || op == 10);
            logic [DAW-1:0] ea = DAW'(mreg[r1] + i6);
            pend_v = 0;
            case (op)
                1: mreg[rd] = mreg[r1] + mreg[r2];
                2: mreg[rd] = mreg[r1] - mreg[r2];
                3: mreg[rd] = mreg[r1] & mreg[r2];
                4: mreg[rd] = mreg[r1] | mreg[r2];
                5: mreg[rd] = mreg[r1] ^ mreg[r2];
                6: mreg[rd] = mreg[r1] + i6;
                7: mreg[rd] = mmem[ea];
                8: begin
                    mmem[ea] = mreg[rd];
                    if (exp_n < 128) begin
                        exp_addr[exp_n] = ea;
                        exp_data[exp_n] = mreg[rd];
                        exp_n++;
                    end
                end
                default: ;
            endcase
            if (ctrl && !slot && (op == 9 || mreg[rd] == 0)) begin
                pend_v = 1;
                pend = (pc + off) & (NP - 1);
            end
            slot = ctrl;
            pc = nxt;
        end
    endtask

    // Memory responder: ready after the chosen latency; logs stores.
    initial begin
        dmem_ready = 1'b0;
        dmem_rdata = '0;
        wcnt = 0;
        forever begin
            @(negedge clk);
            if (rst_n && dmem_req) begin
                if (wcnt >= cur_lat) begin
                    dmem_ready = 1'b1;
                    if (dmem_we) begin
                        dmem[dmem_addr] = dmem_wdata;
                        if (act_n < 128) begin
                            act_addr[act_n] = dmem_addr;
                            act_data[act_n] = dmem_wdata;
                            act_n++;
                        end
                    end else begin
                        dmem_rdata = dmem[dmem_addr];
                    end
                    wcnt = 0;
                    cur_lat = (lat_fix >= 0) ? lat_fix : int'($urandom_range(0, 4));
                end else begin
                    dmem_ready = 1'b0;
                    wcnt++;
                end
            end else begin
                dmem_ready = 1'b0;
                wcnt = 0;
            end
        end
    end

    task automatic clear_prog;
        for (int i = 0; i < NP; i++) prog[i] = 16'h0000;
    endtask

    task automatic start_prog(input int lat);
        for (int a = 0; a < ND; a++) dmem[a] = memval(a);
        act_n = 0;
        lat_fix = lat;
        cur_lat = (lat >= 0) ? lat : 2;
        rst_n = 1'b0;
        repeat (3) sample();
        chk(imem_addr == '0, "R1 reset fetch address", int'(imem_addr), 0);
        chk(!dmem_req, "R1 reset request", int'(dmem_req), 0);
        rst_n = 1'b1;
    endtask

    task automatic end_prog(input string tag);
        repeat (700) sample();
        model_run(400);
        chk(act_n == exp_n, {tag, " store count"}, act_n, exp_n);
        for (int i = 0; i < exp_n && i < act_n; i++) begin
            chk(act_addr[i] == exp_addr[i], {tag, " store address"}, int'(act_addr[i]), int'(exp_addr[i]));
            chk(act_data[i] == exp_data[i], {tag, " store data"}, int'(act_data[i]), int'(exp_data[i]));
        end
    endtask

    task automatic put_halt(input int h);
        prog[h]     = enc_b(9, 0, 0);
        prog[h + 1] = 16'h0000;
    endtask

    task automatic wait_req;
        for (int i = 0; i < 60 && !dmem_req; i++) sample();
    endtask

    task automatic gen_random;
        clear_prog();
        for (int i = 0; i < 40; i++) begin
            int k = int'($urandom_range(0, 11));
            int rd = int'($urandom_range(0, 7)), r1 = int'($urandom_range(0, 7));
            int r2 = int'($urandom_range(0, 7)), im = int'($urandom_range(0, 63));
            case (k)
                0, 1, 2, 3: prog[i] = enc_r(int'($urandom_range(1, 5)), rd, r1, r2);
                4, 5:       prog[i] = enc_i(6, rd, r1, im);
                6, 7:       prog[i] = enc_i(7, rd, r1, im);
                8:          prog[i] = enc_i(8, rd, r1, im);
                9:          prog[i] = enc_b(9 + int'($urandom_range(0, 1)), rd, int'($urandom_range(2, 6)));
                10:         prog[i] = enc_b(10, rd, int'($urandom_range(2, 6)));
                default:    prog[i] = {4'(11 + $urandom_range(0, 4)), 12'($urandom())};
            endcase
        end
        for (int i = 0; i < 8; i++) prog[40 + i] = enc_i(8, i, 0, 8 * i);
        put_halt(48);
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0D5B));
        clear_prog();

        // Delay slot always executes; slot branch ignored (R5 R6).
        prog[0]  = enc_i(6, 1, 0, 5);
        prog[1]  = enc_b(9, 0, 4);
        prog[2]  = enc_i(6, 2, 0, 7);
        prog[3]  = enc_i(6, 3, 0, 9);
        prog[4]  = enc_i(6, 3, 0, 11);
        prog[5]  = enc_b(10, 0, 4);
        prog[6]  = enc_b(9, 0, 8);
        prog[7]  = enc_i(6, 4, 0, 1);
        prog[8]  = enc_i(6, 4, 0, 2);
        prog[9]  = enc_b(10, 1, 20);
        prog[10] = enc_i(8, 1, 0, 0);
        prog[11] = enc_i(8, 2, 0, 1);
        prog[12] = enc_i(8, 3, 0, 2);
        prog[13] = enc_i(8, 4, 0, 3);
        put_halt(14);
        start_prog(1);
        end_prog("R5 R6 delay slot");
        chk(act_n == 4, "R5 taken jump store count", act_n, 4);
        if (act_n == 4) begin
            chk(act_data[0] == 16'd5, "R3 immediate add", int'(act_data[0]), 5);
            chk(act_data[1] == 16'd7, "R5 delay slot executed", int'(act_data[1]), 7);
            chk(act_data[2] == 16'd0, "R5 skipped after jump", int'(act_data[2]), 0);
            chk(act_data[3] == 16'd0, "R6 slot branch no redirect", int'(act_data[3]), 0);
        end

        // Independent instructions pass a pending load; consumer waits (R7 R8 R11 R12).
        clear_prog();
        prog[0] = enc_i(7, 1, 0, 3);
        prog[1] = enc_i(6, 2, 0, 7);
        prog[2] = enc_i(6, 3, 0, 9);
        prog[3] = enc_r(1, 4, 1, 2);
        prog[4] = enc_i(8, 4, 0, 10);
        prog[5] = {4'hC, 3'd2, 9'h1FF};
        prog[6] = enc_i(8, 2, 0, 11);
        prog[7] = enc_i(8, 3, 0, 12);
        put_halt(8);
        start_prog(10);
        wait_req();
        repeat (5) sample();
        chk(imem_addr == 6'd4, "R7 issue past load, R8 consumer stalled", int'(imem_addr), 4);
        repeat (6) sample();
        chk(imem_addr == 6'd4, "R8 consumer still waits in ready cycle", int'(imem_addr), 4);
        chk(!dmem_req, "R11 load retired at ready", int'(dmem_req), 0);
        sample();
        chk(imem_addr == 6'd5, "R8 R11 consumer runs after ready", int'(imem_addr), 5);
        end_prog("R7 R8 R11 R12 load lock");
        if (act_n >= 2) begin
            chk(act_data[0] == memval(3) + 16'd7, "R8 loaded value used", int'(act_data[0]), int'(memval(3) + 16'd7));
            chk(act_data[1] == 16'd7, "R12 unused opcode no effect", int'(act_data[1]), 7);
        end

        // Second load stalls behind the first (R9).
        clear_prog();
        prog[0] = enc_i(7, 1, 0, 1);
        prog[1] = enc_i(7, 2, 0, 2);
        prog[2] = enc_i(6, 3, 0, 1);
        prog[3] = enc_i(8, 1, 0, 20);
        prog[4] = enc_i(8, 2, 0, 21);
        put_halt(5);
        start_prog(8);
        wait_req();
        repeat (5) sample();
        chk(imem_addr == 6'd2, "R9 second load stalled", int'(imem_addr), 2);
        end_prog("R9 back-to-back loads");

        // Non-load write to the locked register waits; later value stays (R10).
        clear_prog();
        prog[0] = enc_i(7, 1, 0, 1);
        prog[1] = enc_i(6, 1, 0, 5);
        prog[2] = enc_i(8, 1, 0, 20);
        put_halt(3);
        start_prog(8);
        wait_req();
        repeat (5) sample();
        chk(imem_addr == 6'd2, "R10 write to locked register stalled", int'(imem_addr), 2);
        end_prog("R10 write ordering");
        if (act_n == 1)
            chk(act_data[0] == 16'd5, "R10 final value is later write", int'(act_data[0]), 5);

        // Random programs, random and zero latency (R2 R3 R4 R5 R9 R12).
        for (int p = 0; p < 4; p++) begin
            gen_random();
            start_prog(p == 3 ? 0 : -1);
            end_prog("R2 R3 R4 R5 random program");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule